// File: doc/BRIEF.md
# Banked Register File Decoder

This block sits between a small CPU's 7-bit direct data address and a banked data space. The active bank comes from two bits of a status register that the block holds itself. The 9-bit logical address is {bank, offset}, so four banks of 128 offsets give 512 logical locations. In each bank the offsets below a per-bank boundary are special function registers and the offsets from the boundary upwards are general purpose RAM. The first few special offsets are core registers. These are mirrored so that the same physical register is reached from every bank. The peripheral special registers that follow are separate in each bank. Any special offset that is left over in a bank is unimplemented.

The decode is combinational. For each access the block drives either a flat index into an external RAM that packs together the RAM regions of all banks, or a one-hot select over the special registers. It also returns the read byte, chosen from the RAM, from the peripherals' read bus, or from its own status register. Only the status register is clocked. A write to it changes the bank from the next cycle on.

Top module: `brf_decoder`

## Requirements
- R1: `bank` equals {status bit 6, status bit 5}. It changes only on the clock edge that completes a status write.
- R2: Offset 03h is the status register in every bank. A write there loads `acc_wdata` into the status register at the next edge. A read there returns the status register. `sfr_sel` and `sfr_we` stay 0 for this offset.
- R3: Offsets 00h, 01h and 02h are core registers mirrored in all banks. Offset n selects `sfr_sel` bit n whatever the bank.
- R4: In bank b, the peripheral offsets run from 04h to 04h+PER_CNT[b]-1. Offset o selects bit o+sum(PER_CNT[0..b-1]). With the defaults (10, 8, 6, 0) each bank reaches different select bits.
- R5: Offsets from 04h+PER_CNT[b] up to SFR_END[b]-1 are unimplemented. Reads there return 00h, `ram_en`, `sfr_sel`, `ram_we` and `sfr_we` stay 0, and writes change nothing.
- R6: Offsets SFR_END[b] to 7Fh drive `ram_en`=1 and `ram_idx` = base[b] + offset - SFR_END[b]. base[b] is the sum of (128 - SFR_END[i]) for i<b. With the defaults (20h, 20h, 10h, 10h) the bases are 0, 96, 192 and 304. When `ram_en` is 0, `ram_idx` is 0.
- R7: `acc_rdata` returns `ram_rdata` for a RAM offset, byte k (bits 8k+7..8k) of `sfr_rdata` for a special register with select bit k, and the status register at offset 03h.
- R8: `ram_we` is `acc_we` gated by a RAM hit. `sfr_we` is `acc_we` gated by a special-register hit. `sfr_sel` has at most one bit set.
- R9: Reset clears the status register to 00h, which selects bank 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_ofs | input | 7 | Direct offset within the active bank |
| acc_we | input | 1 | Write strobe for the current access |
| acc_wdata | input | 8 | Write data |
| acc_rdata | output | 8 | Read data for the current access |
| bank | output | 2 | Active bank from the status register |
| ram_en | output | 1 | Access hits general purpose RAM |
| ram_we | output | 1 | RAM write strobe |
| ram_idx | output | RAM_AW (9) | Flat RAM index |
| ram_rdata | input | 8 | RAM read data for `ram_idx` |
| sfr_sel | output | NSFR (28) | One-hot special register select |
| sfr_we | output | 1 | Special register write strobe |
| sfr_rdata | input | NSFR*8 (224) | Read bytes of all special registers, slot k at bits 8k+7..8k |

## Verification
The assertions assume that `acc_ofs`, `acc_we` and `acc_wdata` are known and stay stable from just after one clock edge until the next. They also assume that `ram_rdata` follows `ram_idx` combinationally. The bench drives every input one time unit after the rising edge and compares against its own model at the falling edge. It supplies `ram_rdata` as a fixed function of `ram_idx` and fills `sfr_rdata` with a distinct byte per slot. Reset is asserted only while `acc_we` is low, so the status register is never written and reset in the same cycle.

// File: rtl/brf_pkg.sv
package brf_pkg;
    localparam int OFS_W     = 7;
    localparam int BANK_W    = 2;
    localparam int NBANK     = 4;
    localparam int BANK_SPAN = 128;
    localparam int DATA_W    = 8;
    localparam int RP0_BIT   = 5;
    localparam int RP1_BIT   = 6;

    typedef enum logic [1:0] {
        K_NONE = 2'd0,
        K_STAT = 2'd1,
        K_SFR  = 2'd2,
        K_RAM  = 2'd3
    } kind_e;

    typedef struct packed {
        logic [DATA_W-1:0] status;
    } state_t;

    // sum of the first n entries of a per-bank table
    function automatic int sum_first(input int a [NBANK], input int n);
        int s;
        s = 0;
        for (int i = 0; i < NBANK; i++) begin
            if (i < n) s += a[i];
        end
        return s;
    endfunction
endpackage

// File: rtl/brf_bank_map.sv
module brf_bank_map
    import brf_pkg::*;
#(
    parameter int CORE_N          = 4,
    parameter int STAT_OFS        = 3,
    parameter int SFR_END [NBANK] = '{32, 32, 16, 16},
    parameter int PER_CNT [NBANK] = '{10, 8, 6, 0},
    parameter int SFR_IW          = 5,
    parameter int RAM_AW          = 9
) (
    input  logic [BANK_W-1:0] bank,
    input  logic [OFS_W-1:0]  ofs,
    output kind_e             kind,
    output logic [SFR_IW-1:0] sfr_idx,
    output logic [RAM_AW-1:0] ram_idx
);
    typedef struct packed {
        kind_e             kind;
        logic [SFR_IW-1:0] si;
        logic [RAM_AW-1:0] ri;
    } dec_t;

    // decode one offset against one bank's layout
    function automatic dec_t decode_at(input int o, input int pb, input int rb,
                                       input int se, input int pc);
        dec_t r;
        r.kind = K_NONE;
        r.si   = '0;
        r.ri   = '0;
        if (o < CORE_N) begin
            r.si   = SFR_IW'(o);
            r.kind = (o == STAT_OFS) ? K_STAT : K_SFR;
        end else if (o < CORE_N + pc) begin
            r.kind = K_SFR;
            r.si   = SFR_IW'(o + pb);
        end else if (o >= se) begin
            r.kind = K_RAM;
            r.ri   = RAM_AW'(o - se + rb);
        end
        return r;
    endfunction

    dec_t dec [NBANK];
    dec_t hit;

    for (genvar g = 0; g < NBANK; g++) begin : g_bank
        localparam int PB = sum_first(PER_CNT, g);
        localparam int RB = g * BANK_SPAN - sum_first(SFR_END, g);
        localparam int SE = SFR_END[g];
        localparam int PC = PER_CNT[g];
        assign dec[g] = decode_at(int'(ofs), PB, RB, SE, PC);
    end

    assign hit     = dec[bank];
    assign kind    = hit.kind;
    assign sfr_idx = hit.si;
    assign ram_idx = hit.ri;
endmodule

// File: rtl/brf_rd_mux.sv
module brf_rd_mux
    import brf_pkg::*;
#(
    parameter int NSFR   = 28,
    parameter int SFR_IW = 5
) (
    input  kind_e                   kind,
    input  logic [SFR_IW-1:0]       sfr_idx,
    input  logic [DATA_W-1:0]       status,
    input  logic [DATA_W-1:0]       ram_rdata,
    input  logic [NSFR*DATA_W-1:0]  sfr_rdata,
    output logic [DATA_W-1:0]       rdata
);
    logic [DATA_W-1:0] slot [NSFR];

    for (genvar i = 0; i < NSFR; i++) begin : g_slot
        assign slot[i] = sfr_rdata[i*DATA_W +: DATA_W];
    end

    always_comb begin
        rdata = '0;
        case (kind)
            K_RAM:  rdata = ram_rdata;
            K_STAT: rdata = status;
            K_SFR:  if (int'(sfr_idx) < NSFR) rdata = slot[sfr_idx];
            default: rdata = '0;
        endcase
    end
endmodule

// File: rtl/brf_decoder.sv
module brf_decoder
    import brf_pkg::*;
#(
    parameter int CORE_N          = 4,
    parameter int STAT_OFS        = 3,
    parameter int SFR_END [NBANK] = '{32, 32, 16, 16},
    parameter int PER_CNT [NBANK] = '{10, 8, 6, 0},
    localparam int NSFR      = CORE_N + sum_first(PER_CNT, NBANK),
    localparam int RAM_TOTAL = NBANK * BANK_SPAN - sum_first(SFR_END, NBANK),
    localparam int SFR_IW    = $clog2(NSFR),
    localparam int RAM_AW    = $clog2(RAM_TOTAL)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [OFS_W-1:0]         acc_ofs,
    input  logic                     acc_we,
    input  logic [DATA_W-1:0]        acc_wdata,
    output logic [DATA_W-1:0]        acc_rdata,
    output logic [BANK_W-1:0]        bank,
    output logic                     ram_en,
    output logic                     ram_we,
    output logic [RAM_AW-1:0]        ram_idx,
    input  logic [DATA_W-1:0]        ram_rdata,
    output logic [NSFR-1:0]          sfr_sel,
    output logic                     sfr_we,
    input  logic [NSFR*DATA_W-1:0]   sfr_rdata
);
    state_t            st_d, st_q;
    kind_e             kind;
    logic [SFR_IW-1:0] sfr_idx;

    // R1: bank bits come straight from the held status register
    assign bank = {st_q.status[RP1_BIT], st_q.status[RP0_BIT]};

    brf_bank_map #(
        .CORE_N  (CORE_N),
        .STAT_OFS(STAT_OFS),
        .SFR_END (SFR_END),
        .PER_CNT (PER_CNT),
        .SFR_IW  (SFR_IW),
        .RAM_AW  (RAM_AW)
    ) u_map (
        .bank   (bank),
        .ofs    (acc_ofs),
        .kind   (kind),
        .sfr_idx(sfr_idx),
        .ram_idx(ram_idx)
    );

    brf_rd_mux #(
        .NSFR  (NSFR),
        .SFR_IW(SFR_IW)
    ) u_mux (
        .kind     (kind),
        .sfr_idx  (sfr_idx),
        .status   (st_q.status),
        .ram_rdata(ram_rdata),
        .sfr_rdata(sfr_rdata),
        .rdata    (acc_rdata)
    );

    // R6, R8: RAM strobes
    assign ram_en = (kind == K_RAM);
    assign ram_we = acc_we && ram_en;

    // R3, R4, R8: one-hot special register select
    for (genvar i = 0; i < NSFR; i++) begin : g_sel
        assign sfr_sel[i] = (kind == K_SFR) && (sfr_idx == SFR_IW'(i));
    end
    assign sfr_we = acc_we && (kind == K_SFR);

    // R2: status register next value
    always_comb begin
        st_d = st_q;
        if (acc_we && kind == K_STAT) st_d.status = acc_wdata;
    end

    // R9: reset clears status
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    a_r8_sel_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(sfr_sel));
    a_r8_ram_we_gated: assert property (@(posedge clk) disable iff (!rst_n)
        ram_we |-> ram_en);
    a_r8_sfr_we_gated: assert property (@(posedge clk) disable iff (!rst_n)
        sfr_we |-> (sfr_sel != '0));
    a_r2_status_load: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_we && kind == K_STAT) |=> (st_q.status == $past(acc_wdata)));
    a_r1_bank_steady: assert property (@(posedge clk) disable iff (!rst_n)
        !(acc_we && kind == K_STAT) |=> $stable(bank));
    a_r5_unimpl_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (kind == K_NONE) |-> (acc_rdata == '0 && !ram_en && sfr_sel == '0));
    a_r6_ram_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        ram_en |-> (int'(ram_idx) < RAM_TOTAL));
    a_r3_core_mirror: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(acc_ofs) < CORE_N && int'(acc_ofs) != STAT_OFS)
            |-> (int'(sfr_idx) == int'(acc_ofs) && kind == K_SFR));
endmodule

// File: tb/sim_brf_decoder.sv
module sim_brf_decoder;
    localparam int CLK_PERIOD = 10;
    localparam int NSFR = 28;
    localparam int RAW  = 9;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [6:0]       acc_ofs = '0;
    logic             acc_we = 1'b0;
    logic [7:0]       acc_wdata = '0;
    logic [7:0]       acc_rdata;
    logic [1:0]       bank;
    logic             ram_en, ram_we, sfr_we;
    logic [RAW-1:0]   ram_idx;
    logic [7:0]       ram_rdata;
    logic [NSFR-1:0]  sfr_sel;
    logic [NSFR*8-1:0] sfr_rdata;

    int checks = 0;
    int failures = 0;
    int model_status = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [7:0] ram_fn(input int idx);
        return 8'((idx * 7 + 13) ^ (idx >> 8));
    endfunction

    assign ram_rdata = ram_fn(int'(ram_idx));

    for (genvar i = 0; i < NSFR; i++) begin : g_fill
        assign sfr_rdata[i*8 +: 8] = (i == 3) ? 8'hEE : 8'(8'h80 + i);
    end

    brf_decoder u0 (
        .clk(clk), .rst_n(rst_n), .acc_ofs(acc_ofs), .acc_we(acc_we),
        .acc_wdata(acc_wdata), .acc_rdata(acc_rdata), .bank(bank),
        .ram_en(ram_en), .ram_we(ram_we), .ram_idx(ram_idx),
        .ram_rdata(ram_rdata), .sfr_sel(sfr_sel), .sfr_we(sfr_we),
        .sfr_rdata(sfr_rdata)
    );

    // reference layout tables taken from the requirements
    int se_t [4] = '{32, 32, 16, 16};
    int pc_t [4] = '{10, 8, 6, 0};
    int pb_t [4] = '{0, 10, 18, 24};
    int rb_t [4] = '{0, 96, 192, 304};

    // kind: 0 none, 1 status, 2 special, 3 ram
    function automatic void ref_dec(input int b, input int o, output int kind, output int idx);
        kind = 0; idx = 0;
        if (o < 4) begin
            kind = (o == 3) ? 1 : 2; idx = o;
        end else if (o < 4 + pc_t[b]) begin
            kind = 2; idx = o + pb_t[b];
        end else if (o >= se_t[b]) begin
            kind = 3; idx = rb_t[b] + o - se_t[b];
        end
    endfunction

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic compare();
        int b, kind, idx, exp_rd;
        logic [NSFR-1:0] exp_sel;
        b = (model_status >> 5) & 3;
        ref_dec(b, int'(acc_ofs), kind, idx);
        exp_sel = '0;
        if (kind == 2) exp_sel[idx] = 1'b1;
        case (kind)
            1: exp_rd = model_status;
            2: exp_rd = 8'h80 + idx;
            3: exp_rd = int'(ram_fn(idx));
            default: exp_rd = 0;
        endcase
        chk(int'(bank) == b, "R1 bank", int'(bank), b);
        if (kind == 0)
            chk(int'(acc_rdata) == 0, "R5 unimplemented read", int'(acc_rdata), 0);
        else if (kind == 1)
            chk(int'(acc_rdata) == exp_rd, "R2 status read", int'(acc_rdata), exp_rd);
        else
            chk(int'(acc_rdata) == exp_rd, "R7 read data", int'(acc_rdata), exp_rd);
        chk(ram_en == (kind == 3), "R6 ram_en", int'(ram_en), int'(kind == 3));
        chk(int'(ram_idx) == ((kind == 3) ? idx : 0), "R6 ram_idx", int'(ram_idx),
            (kind == 3) ? idx : 0);
        if (int'(acc_ofs) < 4)
            chk(sfr_sel == exp_sel, "R3 core select", int'(sfr_sel), int'(exp_sel));
        else
            chk(sfr_sel == exp_sel, "R4 peripheral select", int'(sfr_sel), int'(exp_sel));
        chk(ram_we == (acc_we && kind == 3), "R8 ram_we", int'(ram_we), int'(acc_we && kind == 3));
        chk(sfr_we == (acc_we && kind == 2), "R8 sfr_we", int'(sfr_we), int'(acc_we && kind == 2));
        if (acc_we && kind == 1) model_status = int'(acc_wdata);
    endtask

    task automatic step(input int o, input bit we, input int wd);
        @(posedge clk);
        #1;
        acc_ofs = 7'(o); acc_we = we; acc_wdata = 8'(wd);
        @(negedge clk);
        compare();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // R9: reset state is status 00h, bank 0
        chk(bank == 2'd0, "R9 reset bank", int'(bank), 0);
        step(3, 1'b0, 0);
        chk(acc_rdata == 8'h00, "R9 reset status", int'(acc_rdata), 0);

        // sweep every offset in every bank
        for (int b = 0; b < 4; b++) begin
            step(3, 1'b1, b << 5);
            for (int o = 0; o < 128; o++) step(o, 1'b0, 0);
        end

        // R5: writes to unimplemented offsets in bank 3 change nothing
        step(3, 1'b1, 8'h60);
        for (int o = 4; o < 16; o++) step(o, 1'b1, 8'h20);
        step(3, 1'b0, 0);
        chk(acc_rdata == 8'h60, "R5 status untouched", int'(acc_rdata), 8'h60);

        // R2: status written from each bank, mirrored bits all kept
        for (int b = 0; b < 4; b++) begin
            step(3, 1'b1, (b << 5) | 8'h9);
            step(3, 1'b0, 0);
        end

        // mixed random traffic
        for (int n = 0; n < 3000; n++) begin
            int o;
            o = int'($urandom_range(0, 127));
            if ($urandom_range(0, 9) == 0) o = 3;
            step(o, 1'($urandom_range(0, 1)), int'($urandom_range(0, 255)));
        end

        // R9: reset in the middle of a run
        step(3, 1'b1, 8'h40);
        step(0, 1'b0, 0);
        #1 rst_n = 1'b0;
        model_status = 0;
        @(negedge clk);
        chk(bank == 2'd0, "R9 mid-run reset", int'(bank), 0);
        @(posedge clk);
        #1 rst_n = 1'b1;
        step(3, 1'b0, 0);
        step(40, 1'b0, 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule